// File: doc/BRIEF.md
# Signaling Channel Change Detector

This block watches a set of per-time-slot control/indication or signaling channels that arrive once per frame. Each slot value is masked to the active channel width, compared against a per-slot stored copy, and filtered before a change is accepted. Narrow 4-bit channels accept a difference on the first sighting. The 6-bit and 8-bit channels need the same new value at two consecutive sampling points. Those sampling points are spaced by a programmable number of frames.

Every accepted change updates the stored copy and queues the slot number in a small address FIFO. The interrupt stays high while that FIFO holds anything. The host pops slot numbers from the head of the FIFO and reads any slot's stored value through a separate read port. A FIFO that is full when a change arrives drops the address and sets a sticky overflow flag, but the stored value is still updated.

Top module: `signaling_change_detector`

## Requirements
- R1: `mode` selects the channel width. 2'b00 compares `slot_data[3:0]`, and bits [5:4] of that slot are data-link bits that never count as a change. 2'b01 compares `slot_data[5:0]`. 2'b10 and 2'b11 compare all 8 bits. The stored value is the masked value, zero-extended.
- R2: The first time a slot is sampled after reset, its value is loaded into the stored copy with no FIFO push and no interrupt.
- R3: In 4-bit mode a sample that differs from the stored copy is accepted immediately. After the clock edge that takes the sample, `mem_rdata` for that slot shows the new value, the slot number is at the FIFO tail, and `fifo_level` has grown by one.
- R4: In 6-bit and 8-bit modes a single differing sample changes neither the stored copy nor the FIFO. The same new value seen at the next sampling point of that slot is accepted.
- R5: In 6-bit and 8-bit modes, a differing sample that does not match the pending candidate replaces the candidate and restarts confirmation.
- R6: With `period_sel` = P, frame k (k = 0 at the first `frame_start` after reset) is a sampling frame for 6-bit and 8-bit modes exactly when k mod (P+1) = P. Slot samples in other frames are ignored. 4-bit mode samples every frame whatever P is.
- R7: The FIFO holds 9 slot numbers in arrival order. `fifo_head` shows the oldest, and `rd_pop` removes it. `irq` is high exactly while `fifo_level` is non-zero.
- R8: An accepted change that meets a full FIFO (with no pop in the same cycle) drops the address and sets `overflow`, which stays set until reset. The stored copy is still updated.
- R9: Reset empties the FIFO, clears `irq` and `overflow`, zeroes every stored copy, drops pending candidates and restarts the frame timer.
- R10: In 6-bit and 8-bit modes, a sample equal to the stored copy cancels a pending candidate, so a later repeat of that candidate needs two sightings again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse opening a frame; slots follow in later cycles |
| period_sel | input | 8 | Sampling interval minus one, in frames (6/8-bit modes) |
| mode | input | 2 | Channel width select (see R1) |
| slot_valid | input | 1 | Qualifies slot_addr and slot_data |
| slot_addr | input | 5 | Slot number of the received value |
| slot_data | input | 8 | Received channel value |
| rd_pop | input | 1 | Host pop of the FIFO head |
| irq | output | 1 | Change interrupt, high while the FIFO is non-empty |
| fifo_head | output | 5 | Oldest queued slot number |
| fifo_level | output | 4 | Number of queued slot numbers |
| overflow | output | 1 | Sticky lost-address flag |
| mem_raddr | input | 5 | Host read address of the stored-value memory |
| mem_rdata | output | 8 | Stored value of slot mem_raddr (combinational) |

## Verification
The assertions assume that each slot appears at most once per frame, that `frame_start` and `slot_valid` are never high in the same cycle, and that `mode` and `period_sel` stay fixed between resets, so that candidate state always belongs to a single width. The bench keeps to this. Every test starts from a reset and sets the mode and period before the first frame. Each frame is a lone `frame_start` cycle followed by single-cycle slot presentations. Pops happen only in frames where no slot is being driven.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;

   localparam int CHAN_W = 8;

   typedef enum logic [1:0] {
      WIDTH_4  = 2'b00,
      WIDTH_6  = 2'b01,
      WIDTH_8  = 2'b10,
      WIDTH_8B = 2'b11
   } chan_width_e;

   // Keep only the bits that take part in change detection.
   function automatic logic [CHAN_W-1:0] chan_mask(input logic [1:0] m,
                                                   input logic [CHAN_W-1:0] d);
      logic [CHAN_W-1:0] r;
      case (m)
         WIDTH_4: r = {4'h0, d[3:0]};
         WIDTH_6: r = {2'b00, d[5:0]};
         default: r = d;
      endcase
      return r;
   endfunction

   function automatic logic is_single_look(input logic [1:0] m);
      return m == WIDTH_4;
   endfunction

endpackage

// File: rtl/scd_frame_timer.sv
`timescale 1ns/1ps
module scd_frame_timer #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic [PERIOD_W-1:0] period_sel,
   output logic                sample_frame
);

   logic [PERIOD_W-1:0] frame_cnt;
   logic                hit;

   assign hit = (frame_cnt >= period_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_cnt    <= '0;
         sample_frame <= 1'b0;
      end else if (frame_start) begin
         sample_frame <= hit;
         if (hit) frame_cnt <= '0;
         else     frame_cnt <= frame_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/scd_slot_filter.sv
`timescale 1ns/1ps
module scd_slot_filter
   import scd_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int ADDR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic [CHAN_W-1:0] slot_data,
   input  logic [1:0]        mode,
   input  logic              sample_frame,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CHAN_W-1:0] rd_data,
   output logic              accept,
   output logic [ADDR_W-1:0] accept_addr
);

   localparam logic [ADDR_W:0] SLOT_LIM = NUM_SLOTS[ADDR_W:0];

   logic [NUM_SLOTS-1:0][CHAN_W-1:0] stored_vec;
   logic [NUM_SLOTS-1:0][CHAN_W-1:0] cand_vec;
   logic [NUM_SLOTS-1:0]             cand_ok_vec;
   logic [NUM_SLOTS-1:0]             primed_vec;

   logic              in_range, rd_in_range, single, look;
   logic [CHAN_W-1:0] val, cur_st, cur_cand;
   logic              cur_cv, cur_pr;
   logic              wr_st, wr_cand, nxt_cv;

   assign in_range    = ({1'b0, slot_addr} < SLOT_LIM);
   assign rd_in_range = ({1'b0, rd_addr} < SLOT_LIM);
   assign single      = is_single_look(mode);
   assign look        = slot_valid && in_range && (single || sample_frame);
   assign val         = chan_mask(mode, slot_data);

   assign cur_st   = in_range ? stored_vec[slot_addr]  : '0;
   assign cur_cand = in_range ? cand_vec[slot_addr]    : '0;
   assign cur_cv   = in_range ? cand_ok_vec[slot_addr] : 1'b0;
   assign cur_pr   = in_range ? primed_vec[slot_addr]  : 1'b0;

   // Last-look decision for the slot presented this cycle.
   always_comb begin
      wr_st   = 1'b0;
      wr_cand = 1'b0;
      nxt_cv  = cur_cv;
      accept  = 1'b0;
      if (look) begin
         if (!cur_pr) begin
            wr_st  = 1'b1;
            nxt_cv = 1'b0;
         end else if (val == cur_st) begin
            nxt_cv = 1'b0;
         end else if (single) begin
            wr_st  = 1'b1;
            accept = 1'b1;
         end else if (cur_cv && (cur_cand == val)) begin
            wr_st  = 1'b1;
            accept = 1'b1;
            nxt_cv = 1'b0;
         end else begin
            wr_cand = 1'b1;
            nxt_cv  = 1'b1;
         end
      end
   end

   assign accept_addr = slot_addr;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic              hit;
      logic [CHAN_W-1:0] st_q, cand_q;
      logic              cv_q, pr_q;

      assign hit = look && (slot_addr == ADDR_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= '0;
            cand_q <= '0;
            cv_q   <= 1'b0;
            pr_q   <= 1'b0;
         end else if (hit) begin
            pr_q <= 1'b1;
            cv_q <= nxt_cv;
            if (wr_st)   st_q   <= val;
            if (wr_cand) cand_q <= val;
         end
      end

      assign stored_vec[i]  = st_q;
      assign cand_vec[i]    = cand_q;
      assign cand_ok_vec[i] = cv_q;
      assign primed_vec[i]  = pr_q;
   end

   assign rd_data = rd_in_range ? stored_vec[rd_addr] : '0;

endmodule

// File: rtl/scd_addr_fifo.sv
`timescale 1ns/1ps
module scd_addr_fifo #(
   parameter int DEPTH = 9,
   parameter int W     = 5,
   parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [LVL_W-1:0] level,
   output logic             overflow
);

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   logic [W-1:0]     slots [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_pop, do_push, full, drop;

   // Pointer wrap: free-running for power-of-two depth, compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
   end

   assign full    = (level == FULL_LVL);
   assign do_pop  = pop && (level != '0);
   assign do_push = push && (!full || do_pop);
   assign drop    = push && full && !do_pop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overflow <= 1'b0;
         for (int k = 0; k < DEPTH; k++) slots[k] <= '0;
      end else begin
         if (do_push) begin
            slots[wr_ptr] <= push_data;
            wr_ptr        <= wr_nxt;
         end
         if (do_pop) rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
         if (drop) overflow <= 1'b1;
      end
   end

   assign head = slots[rd_ptr];

endmodule

// File: rtl/signaling_change_detector.sv
`timescale 1ns/1ps
module signaling_change_detector
   import scd_pkg::*;
#(
   parameter int NUM_SLOTS  = 32,
   parameter int FIFO_DEPTH = 9,
   parameter int PERIOD_W   = 8,
   parameter int ADDR_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic [PERIOD_W-1:0] period_sel,
   input  logic [1:0]          mode,
   input  logic                slot_valid,
   input  logic [ADDR_W-1:0]   slot_addr,
   input  logic [CHAN_W-1:0]   slot_data,
   input  logic                rd_pop,
   output logic                irq,
   output logic [ADDR_W-1:0]   fifo_head,
   output logic [LVL_W-1:0]    fifo_level,
   output logic                overflow,
   input  logic [ADDR_W-1:0]   mem_raddr,
   output logic [CHAN_W-1:0]   mem_rdata
);

   initial begin
      assert (NUM_SLOTS >= 2 && NUM_SLOTS <= 1024)
         else $error("NUM_SLOTS out of range");
      assert (FIFO_DEPTH >= 2 && FIFO_DEPTH <= 256)
         else $error("FIFO_DEPTH out of range");
      assert (PERIOD_W >= 1 && PERIOD_W <= 16)
         else $error("PERIOD_W out of range");
   end

   logic              sample_frame;
   logic              accept;
   logic [ADDR_W-1:0] accept_addr;

   scd_frame_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (frame_start),
      .period_sel   (period_sel),
      .sample_frame (sample_frame)
   );

   scd_slot_filter #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_valid   (slot_valid),
      .slot_addr    (slot_addr),
      .slot_data    (slot_data),
      .mode         (mode),
      .sample_frame (sample_frame),
      .rd_addr      (mem_raddr),
      .rd_data      (mem_rdata),
      .accept       (accept),
      .accept_addr  (accept_addr)
   );

   scd_addr_fifo #(.DEPTH(FIFO_DEPTH), .W(ADDR_W), .LVL_W(LVL_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_data (accept_addr),
      .pop       (rd_pop),
      .head      (fifo_head),
      .level     (fifo_level),
      .overflow  (overflow)
   );

   assign irq = (fifo_level != '0);

endmodule

// File: rtl/scd_checker.sv
`timescale 1ns/1ps
module scd_checker #(
   parameter int FIFO_DEPTH = 9,
   parameter int LVL_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             accept,
   input logic             slot_valid,
   input logic             sample_frame,
   input logic [1:0]       mode,
   input logic             rd_pop,
   input logic             irq,
   input logic [LVL_W-1:0] fifo_level,
   input logic             overflow
);

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= FULL_LVL);

   assert_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rd_pop && fifo_level < FULL_LVL)
      |=> fifo_level == $past(fifo_level) + LVL_W'(1));

   assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && fifo_level != '0 && !accept)
      |=> fifo_level == $past(fifo_level) - LVL_W'(1));

   assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(accept));

   assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rd_pop && fifo_level == FULL_LVL)
      |=> (overflow && fifo_level == FULL_LVL));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (slot_valid && (mode == 2'b00 || sample_frame)));

endmodule

bind signaling_change_detector scd_checker #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .LVL_W      (LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .accept       (accept),
   .slot_valid   (slot_valid),
   .sample_frame (sample_frame),
   .mode         (mode),
   .rd_pop       (rd_pop),
   .irq          (irq),
   .fifo_level   (fifo_level),
   .overflow     (overflow)
);

// File: tb/tb_signaling_change_detector.sv
`timescale 1ns/1ps
module tb_signaling_change_detector;

   logic       clk = 1'b0;
   logic       rst_n, frame_start, slot_valid, rd_pop;
   logic [7:0] period_sel, slot_data, mem_rdata;
   logic [1:0] mode;
   logic [4:0] slot_addr, mem_raddr, fifo_head;
   logic [3:0] fifo_level;
   logic       irq, overflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   signaling_change_detector dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .period_sel(period_sel),
      .mode(mode), .slot_valid(slot_valid), .slot_addr(slot_addr), .slot_data(slot_data),
      .rd_pop(rd_pop), .irq(irq), .fifo_head(fifo_head), .fifo_level(fifo_level),
      .overflow(overflow), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
   );

   always #4 clk = ~clk;

   // {slot data, expected stored value, expected fifo level}; 6-bit mode, every frame sampled
   localparam logic [23:0] VEC [12] = '{
      {8'h15, 8'h15, 8'd0},  // R2 prime
      {8'h15, 8'h15, 8'd0},
      {8'h2A, 8'h15, 8'd0},  // R4 first sighting
      {8'h2A, 8'h2A, 8'd1},  // R4 confirmed
      {8'h33, 8'h2A, 8'd1},
      {8'h0C, 8'h2A, 8'd1},  // R5 restart
      {8'h0C, 8'h0C, 8'd2},
      {8'h11, 8'h0C, 8'd2},
      {8'h0C, 8'h0C, 8'd2},  // R10 cancel
      {8'h11, 8'h0C, 8'd2},
      {8'h11, 8'h11, 8'd3},
      {8'hD1, 8'h11, 8'd3}   // R1 upper bits masked
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic [7:0] p);
      rst_n = 1'b0; frame_start = 1'b0; slot_valid = 1'b0; rd_pop = 1'b0;
      slot_addr = '0; slot_data = '0; mem_raddr = '0;
      mode = m; period_sel = p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic frame();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic slot(input logic [4:0] a, input logic [7:0] d);
      slot_valid = 1'b1; slot_addr = a; slot_data = d;
      @(negedge clk);
      slot_valid = 1'b0;
   endtask

   task automatic pop();
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic rdmem(input logic [4:0] a, output logic [7:0] v);
      mem_raddr = a;
      #1;
      v = mem_rdata;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      @(negedge clk);

      // Reset state
      do_reset(2'b01, 8'd0);
      chk("R9 irq after reset", irq, 0);
      chk("R9 overflow after reset", overflow, 0);
      chk("R9 level after reset", fifo_level, 0);
      rdmem(5'd0, v);
      chk("R9 memory after reset", v, 0);

      // Vector table: 6-bit mode, P=0, slot 5
      for (int i = 0; i < 12; i++) begin
         frame();
         slot(5'd5, VEC[i][23:16]);
         rdmem(5'd5, v);
         chk($sformatf("R4/R5/R10 vector %0d stored", i), v, VEC[i][15:8]);
         chk($sformatf("R3/R7 vector %0d level", i), fifo_level, VEC[i][7:0]);
      end
      for (int i = 0; i < 3; i++) begin
         chk("R7 head of queued slot", fifo_head, 5);
         pop();
      end
      chk("R7 irq low after draining", irq, 0);

      // 4-bit mode: immediate acceptance, data-link bits excluded
      do_reset(2'b00, 8'd5);
      frame();
      slot(5'd1, 8'h37);
      rdmem(5'd1, v);
      chk("R1 4-bit masked prime", v, 8'h07);
      chk("R2 no irq on prime", irq, 0);
      frame();
      slot(5'd1, 8'h27);
      chk("R1 data-link bit change ignored", fifo_level, 0);
      frame();
      slot(5'd1, 8'h09);
      rdmem(5'd1, v);
      chk("R3 4-bit immediate stored", v, 8'h09);
      chk("R3 4-bit immediate level", fifo_level, 1);
      chk("R3 4-bit head", fifo_head, 1);
      chk("R7 irq while non-empty", irq, 1);
      pop();
      chk("R7 irq low after pop", irq, 0);

      // Sampling interval: 8-bit mode, P=2 -> frames 2,5,8 sampled
      do_reset(2'b10, 8'd2);
      frame(); slot(5'd2, 8'hAA);
      rdmem(5'd2, v);
      chk("R6 frame 0 not sampled", v, 8'h00);
      frame();
      frame(); slot(5'd2, 8'hAA);
      rdmem(5'd2, v);
      chk("R6 frame 2 primes", v, 8'hAA);
      frame(); slot(5'd2, 8'h55);
      frame(); slot(5'd2, 8'h55);
      rdmem(5'd2, v);
      chk("R6 off-interval samples ignored", v, 8'hAA);
      chk("R6 off-interval level", fifo_level, 0);
      frame(); slot(5'd2, 8'h55);
      chk("R4 one sighting at frame 5", fifo_level, 0);
      frame(); slot(5'd2, 8'h00);
      frame();
      frame(); slot(5'd2, 8'h55);
      rdmem(5'd2, v);
      chk("R6 confirmed at frame 8 stored", v, 8'h55);
      chk("R6 confirmed at frame 8 level", fifo_level, 1);
      chk("R6 confirmed head", fifo_head, 2);

      // FIFO full: 10 changes, 9 kept
      do_reset(2'b00, 8'd0);
      frame();
      for (int s = 0; s < 11; s++) slot(5'(s), 8'h03);
      chk("R2 priming raises no change", fifo_level, 0);
      frame();
      for (int s = 0; s < 10; s++) slot(5'(s), 8'h0C);
      chk("R8 level saturates at 9", fifo_level, 9);
      chk("R8 overflow set", overflow, 1);
      rdmem(5'd9, v);
      chk("R8 dropped slot still stored", v, 8'h0C);
      for (int s = 0; s < 9; s++) begin
         chk($sformatf("R7 order entry %0d", s), fifo_head, s);
         pop();
      end
      chk("R7 empty after pops", fifo_level, 0);
      chk("R8 overflow sticky", overflow, 1);

      do_reset(2'b00, 8'd0);
      chk("R9 overflow cleared by reset", overflow, 0);
      rdmem(5'd9, v);
      chk("R9 memory cleared by reset", v, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule